// File: doc/BRIEF.md
# Serial-Loaded Synthesizer Control Bank

This block is the programming front end of a frequency synthesizer. A host shifts a 24-bit word in over three wires (a serial clock, a data line and a latch strobe), most significant bit first, while the strobe is low. Raising the strobe moves the word into one of four destinations, chosen by the word's two lowest bits: the reference-divider settings, the dual-counter settings, the function settings, or an initialisation entry. The initialisation entry loads the function settings as well and also gives the counters a one-cycle reset pulse.

All three serial wires are sampled by the block's own clock. A rising edge is found by comparing the last two samples. The stored settings go out as named fields: divider values, current codes and prescaler choice are passed through untouched. The block decodes the fastlock controls, the counter reset and the multiplexed status output. If a word arrives with the wrong number of bits, it is dropped and a sticky error flag is raised.

Top module: `synthCtrlBank`

## Requirements
- R1: After reset every field output is 0, muxOe is 0, counterReset is 0 and wordError is 0.
- R2: Bits are sampled on rising serClk edges while serLatch is low, MSB first. On the serLatch rise after exactly 24 bits, the word goes to the destination named by its bits [1:0]: 00 reference, 01 counters, 10 function, 11 initialisation.
- R3: Reference fields: refDivide = bits [15:2], antiBacklash = [17:16], testMode = [19:18], lockPrecise = [20].
- R4: Counter fields: aCount = bits [7:2], bCount = [20:8], cpGainSel = [21].
- R5: Function fields: counterReset follows bit [2], powerMode = {[21],[3]}, phasePolarity = [7], cpTristate = [8], fastlockEn = [9] (on only when 1), fastlockMode = [10], fastlockTimeout = [14:11], cpCurrent1 = [17:15], cpCurrent2 = [20:18], prescaler = [23:22].
- R6: Function bits [6:4] pick the status output. 0: muxOe=0, muxOut=0. 1: lockDet. 2: nDivIn. 3: constant 1. 4: rDivIn. 5: open drain, where muxOut=0 and muxOe=!lockDet. 6: the sampled serData. 7: constant 0. muxOe=1 for every value except 0 and 5.
- R7: An initialisation word loads the function fields and drives counterReset high for exactly one clock, even when its bit [2] is 0.
- R8: If serLatch rises after any bit count other than 24, no destination changes and wordError is set. wordError then stays set until reset.
- R9: Writes are still accepted while powerMode[0] is 1.
- R10: serClk edges while serLatch is high are neither shifted nor counted.
- R11: A write changes only its own destination's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial bit clock |
| serData | input | 1 | Serial data |
| serLatch | input | 1 | Latch strobe, low while shifting |
| lockDet | input | 1 | Lock indicator for the status output |
| nDivIn | input | 1 | Feedback divider output for the status output |
| rDivIn | input | 1 | Reference divider output for the status output |
| refDivide | output | 14 | Reference divide value |
| antiBacklash | output | 2 | Anti-backlash pulse width code |
| testMode | output | 2 | Test code, 00 in normal use |
| lockPrecise | output | 1 | Lock-detect precision select |
| aCount | output | 6 | A counter value |
| bCount | output | 13 | B counter value |
| cpGainSel | output | 1 | Charge-pump gain select |
| counterReset | output | 1 | Counter hold / charge-pump three-state |
| powerMode | output | 2 | Power-down controls |
| phasePolarity | output | 1 | Detector polarity |
| cpTristate | output | 1 | Charge-pump three-state |
| fastlockEn | output | 1 | Fastlock enable |
| fastlockMode | output | 1 | Fastlock mode select |
| fastlockTimeout | output | 4 | Fastlock timer code |
| cpCurrent1 | output | 3 | Charge-pump current code 1 |
| cpCurrent2 | output | 3 | Charge-pump current code 2 |
| prescaler | output | 2 | Prescaler choice |
| muxOut | output | 1 | Status output value |
| muxOe | output | 1 | Status output drive enable |
| wordError | output | 1 | Sticky wrong-length flag |

## Verification
The assertions assume the serial wires are synchronous to clk. They also assume each wire holds a level for at least two clock cycles, so that every edge is seen exactly once, and that serLatch rises only after the last serClk edge has been sampled. The stimulus holds each serial level for two clocks and waits two more before raising the strobe. It keeps the strobe high while idle, so the only strobe rises are the ones that end a word.

// File: rtl/synthCtrlPkg.sv
package synthCtrlPkg;
  typedef struct packed {
    logic shift;
    logic commit;
    logic drop;
  } strobeT;
endpackage

// File: rtl/serialCtrl.sv
module serialCtrl
  import synthCtrlPkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   serClk,
  input  logic   serLatch,
  output strobeT stb,
  output logic   wordError
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

  logic clkQ, clkP, leQ, leP;
  logic [CNT_W-1:0] bitCnt;
  logic clkRise, leRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkQ <= 1'b0; clkP <= 1'b0;
      leQ  <= 1'b1; leP  <= 1'b1;
    end else begin
      clkQ <= serClk; clkP <= clkQ;
      leQ  <= serLatch; leP <= leQ;
    end
  end

  assign clkRise = clkQ & ~clkP;
  assign leRise  = leQ & ~leP;

  always_comb begin
    stb.shift  = clkRise & ~leQ;
    stb.commit = leRise & (bitCnt == FULL);
    stb.drop   = leRise & (bitCnt != FULL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt    <= '0;
      wordError <= 1'b0;
    end else begin
      if (leRise) bitCnt <= '0;
      else if (stb.shift && bitCnt != OVER) bitCnt <= bitCnt + 1'b1;
      if (stb.drop) wordError <= 1'b1;
    end
  end

  // R8
  drop_sets_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.drop |=> wordError);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordError |=> wordError);
  // R10
  no_shift_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (leQ && leP) |-> !stb.shift);
endmodule

// File: rtl/regDatapath.sv
module regDatapath
  import synthCtrlPkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobeT      stb,
  input  logic        serData,
  input  logic        lockDet,
  input  logic        nDivIn,
  input  logic        rDivIn,
  output logic [13:0] refDivide,
  output logic [1:0]  antiBacklash,
  output logic [1:0]  testMode,
  output logic        lockPrecise,
  output logic [5:0]  aCount,
  output logic [12:0] bCount,
  output logic        cpGainSel,
  output logic        counterReset,
  output logic [1:0]  powerMode,
  output logic        phasePolarity,
  output logic        cpTristate,
  output logic        fastlockEn,
  output logic        fastlockMode,
  output logic [3:0]  fastlockTimeout,
  output logic [2:0]  cpCurrent1,
  output logic [2:0]  cpCurrent2,
  output logic [1:0]  prescaler,
  output logic        muxOut,
  output logic        muxOe
);
  localparam int REF_TOP = 20;
  localparam int AB_TOP  = 21;
  localparam int FN_TOP  = WORD_W - 1;

  logic dataQ;
  logic [WORD_W-1:0] shiftReg;
  logic [REF_TOP:ADDR_W] refLat;
  logic [AB_TOP:ADDR_W]  abLat;
  logic [FN_TOP:ADDR_W]  funcLat;
  logic initPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ    <= 1'b0;
      shiftReg <= '0;
    end else begin
      dataQ <= serData;
      if (stb.shift) shiftReg <= {shiftReg[WORD_W-2:0], dataQ};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refLat    <= '0;
      abLat     <= '0;
      funcLat   <= '0;
      initPulse <= 1'b0;
    end else begin
      initPulse <= 1'b0;
      if (stb.commit) begin
        unique case (shiftReg[ADDR_W-1:0])
          2'd0: refLat  <= shiftReg[REF_TOP:ADDR_W];
          2'd1: abLat   <= shiftReg[AB_TOP:ADDR_W];
          2'd2: funcLat <= shiftReg[FN_TOP:ADDR_W];
          default: begin
            funcLat   <= shiftReg[FN_TOP:ADDR_W];
            initPulse <= 1'b1;
          end
        endcase
      end
    end
  end

  assign refDivide       = refLat[15:2];
  assign antiBacklash    = refLat[17:16];
  assign testMode        = refLat[19:18];
  assign lockPrecise     = refLat[20];
  assign aCount          = abLat[7:2];
  assign bCount          = abLat[20:8];
  assign cpGainSel       = abLat[21];
  assign counterReset    = funcLat[2] | initPulse;
  assign powerMode       = {funcLat[21], funcLat[3]};
  assign phasePolarity   = funcLat[7];
  assign cpTristate      = funcLat[8];
  assign fastlockEn      = funcLat[9];
  assign fastlockMode    = funcLat[10];
  assign fastlockTimeout = funcLat[14:11];
  assign cpCurrent1      = funcLat[17:15];
  assign cpCurrent2      = funcLat[20:18];
  assign prescaler       = funcLat[23:22];

  always_comb begin
    muxOe  = 1'b1;
    muxOut = 1'b0;
    unique case (funcLat[6:4])
      3'd0: muxOe  = 1'b0;
      3'd1: muxOut = lockDet;
      3'd2: muxOut = nDivIn;
      3'd3: muxOut = 1'b1;
      3'd4: muxOut = rDivIn;
      3'd5: muxOe  = ~lockDet;
      3'd6: muxOut = dataQ;
      default: muxOut = 1'b0;
    endcase
  end

  // R7
  init_pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    initPulse |=> !initPulse);
  // R11
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(refLat));
  // R11
  func_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(funcLat));
  // R8
  drop_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.drop |=> $stable(abLat));
  // R7
  init_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && shiftReg[1:0] == 2'd3) |=> counterReset);
endmodule

// File: rtl/synthCtrlBank.sv
module synthCtrlBank
  import synthCtrlPkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLatch,
  input  logic        lockDet,
  input  logic        nDivIn,
  input  logic        rDivIn,
  output logic [13:0] refDivide,
  output logic [1:0]  antiBacklash,
  output logic [1:0]  testMode,
  output logic        lockPrecise,
  output logic [5:0]  aCount,
  output logic [12:0] bCount,
  output logic        cpGainSel,
  output logic        counterReset,
  output logic [1:0]  powerMode,
  output logic        phasePolarity,
  output logic        cpTristate,
  output logic        fastlockEn,
  output logic        fastlockMode,
  output logic [3:0]  fastlockTimeout,
  output logic [2:0]  cpCurrent1,
  output logic [2:0]  cpCurrent2,
  output logic [1:0]  prescaler,
  output logic        muxOut,
  output logic        muxOe,
  output logic        wordError
);
  strobeT stb;

  serialCtrl #(.WORD_W(WORD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serLatch(serLatch),
    .stb(stb), .wordError(wordError)
  );

  regDatapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .serData(serData),
    .lockDet(lockDet), .nDivIn(nDivIn), .rDivIn(rDivIn),
    .refDivide(refDivide), .antiBacklash(antiBacklash), .testMode(testMode),
    .lockPrecise(lockPrecise), .aCount(aCount), .bCount(bCount),
    .cpGainSel(cpGainSel), .counterReset(counterReset), .powerMode(powerMode),
    .phasePolarity(phasePolarity), .cpTristate(cpTristate),
    .fastlockEn(fastlockEn), .fastlockMode(fastlockMode),
    .fastlockTimeout(fastlockTimeout), .cpCurrent1(cpCurrent1),
    .cpCurrent2(cpCurrent2), .prescaler(prescaler),
    .muxOut(muxOut), .muxOe(muxOe)
  );
endmodule

// File: tb/sim_synthCtrlBank.sv
`timescale 1ns/1ps
module sim_synthCtrlBank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLatch = 1'b1;
  logic lockDet = 1'b0, nDivIn = 1'b0, rDivIn = 1'b0;
  logic [13:0] refDivide; logic [1:0] antiBacklash, testMode; logic lockPrecise;
  logic [5:0] aCount; logic [12:0] bCount; logic cpGainSel, counterReset;
  logic [1:0] powerMode; logic phasePolarity, cpTristate, fastlockEn, fastlockMode;
  logic [3:0] fastlockTimeout; logic [2:0] cpCurrent1, cpCurrent2; logic [1:0] prescaler;
  logic muxOut, muxOe, wordError;

  always #2.5 clk = ~clk;

  synthCtrlBank u0 (.*);

  typedef struct { logic [60:0] exp; string req; } itemT;
  itemT sbQ[$];
  int checks = 0, fails = 0, pulseCnt = 0;
  logic [23:0] refM = '0, abM = '0, funcM = '0;
  logic errM = 1'b0;

  logic [60:0] obs;
  assign obs = {refDivide, antiBacklash, testMode, lockPrecise, aCount, bCount,
                cpGainSel, counterReset, powerMode, phasePolarity, cpTristate,
                fastlockEn, fastlockMode, fastlockTimeout, cpCurrent1, cpCurrent2,
                prescaler, muxOut, muxOe, wordError};

  function automatic logic [60:0] model();
    logic mo, moe;
    moe = 1'b1; mo = 1'b0;
    case (funcM[6:4])
      3'd0: moe = 1'b0;
      3'd1: mo = lockDet;
      3'd2: mo = nDivIn;
      3'd3: mo = 1'b1;
      3'd4: mo = rDivIn;
      3'd5: moe = !lockDet;
      3'd6: mo = serData;
      default: mo = 1'b0;
    endcase
    return {refM[15:2], refM[17:16], refM[19:18], refM[20], abM[7:2], abM[20:8],
            abM[21], funcM[2], funcM[21], funcM[3], funcM[7], funcM[8], funcM[9],
            funcM[10], funcM[14:11], funcM[17:15], funcM[20:18], funcM[23:22],
            mo, moe, errM};
  endfunction

  function automatic logic [23:0] fw(input logic [2:0] sel, input logic fl,
                                     input logic pd, input logic cr, input logic [1:0] ad);
    return {2'b10, 1'b0, 3'b101, 3'b011, 4'b1001, 1'b1, fl, 2'b01, sel, pd, cr, ad};
  endfunction

  // monitor: pops expected items and compares with the ports
  always @(negedge clk) begin
    if (counterReset && rstN) pulseCnt <= pulseCnt + 1;
    if (sbQ.size() > 0) begin
      itemT it;
      it = sbQ.pop_front();
      checks++;
      if (obs !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.req, obs, it.exp);
      end
    end
  end

  task automatic push(input string req);
    itemT it;
    it.exp = model();
    it.req = req;
    sbQ.push_back(it);
    repeat (2) @(negedge clk);
  endtask

  task automatic sendWord(input logic [31:0] w, input int nbits, input string req);
    serLatch = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      serData = w[i];
      serClk = 1'b0; repeat (2) @(negedge clk);
      serClk = 1'b1; repeat (2) @(negedge clk);
    end
    serClk = 1'b0; repeat (2) @(negedge clk);
    serLatch = 1'b1;
    repeat (6) @(negedge clk);
    if (nbits != 24) errM = 1'b1;
    else case (w[1:0])
      2'd0: refM = w[23:0];
      2'd1: abM = w[23:0];
      default: funcM = w[23:0];
    endcase
    if (nbits == 24 && w[1:0] == 2'd3) funcM[1:0] = 2'd2;
    push(req);
  endtask

  task automatic scalar(input logic act, input logic expv, input string req);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, expv);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5ns * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    int pc;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    push("R1 reset state");

    sendWord(32'h1ABCD4, 24, "R2 R3 reference write");
    sendWord(32'h2F3C5D, 24, "R4 R11 counter write");
    lockDet = 1'b1;
    sendWord({8'h0, fw(3'd1, 1'b1, 1'b0, 1'b0, 2'd2)}, 24, "R5 R6 function fastlock on, lock detect");
    sendWord({8'h0, fw(3'd3, 1'b0, 1'b0, 1'b0, 2'd2)}, 24, "R5 fastlock off only when bit 9 is 0");
    for (int s = 0; s < 8; s++) begin
      lockDet = s[0]; nDivIn = s[1]; rDivIn = ~s[2];
      sendWord({8'h0, fw(3'(s), 1'b0, 1'b0, 1'b0, 2'd2)}, 24, "R6 status output select");
    end
    lockDet = 1'b0;
    sendWord({8'h0, fw(3'd5, 1'b0, 1'b0, 1'b0, 2'd2)}, 24, "R6 open drain with lock low");

    sendWord({8'h0, fw(3'd2, 1'b1, 1'b1, 1'b0, 2'd2)}, 24, "R5 powered down");
    sendWord(32'h0F0F08, 24, "R9 write while powered down");

    pc = pulseCnt;
    sendWord({8'h0, fw(3'd4, 1'b1, 1'b0, 1'b0, 2'd3)}, 24, "R7 init loads function fields");
    scalar(pulseCnt == pc + 1, 1'b1, "R7 single counter reset pulse");
    sendWord({8'h0, fw(3'd4, 1'b0, 1'b0, 1'b1, 2'd2)}, 24, "R5 counter reset bit held");
    scalar(counterReset, 1'b1, "R5 counterReset level");
    sendWord({8'h0, fw(3'd4, 1'b0, 1'b0, 1'b0, 2'd2)}, 24, "R5 counter reset released");

    // edges while latch strobe is high must not be counted
    for (int k = 0; k < 5; k++) begin
      serData = k[0];
      serClk = 1'b1; repeat (2) @(negedge clk);
      serClk = 1'b0; repeat (2) @(negedge clk);
    end
    sendWord(32'h13579D, 24, "R10 no error after idle edges");

    sendWord(32'h0AAAA9, 20, "R8 short word dropped");
    sendWord(32'h3FFFFF5, 26, "R8 long word dropped");
    sendWord(32'h2468A0, 24, "R8 R11 valid write after error");

    while (sbQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule